// File: doc/BRIEF.md
# Wired-AND Bus Arbitration Unit

This block settles which node owns a shared open-drain serial line, one bit at a time. On the shared wire a dominant level always overrides a recessive one. The node samples the line back on every bit and compares it with what it drove. While the identifier bits are on the wire, a node that drove recessive but reads dominant has been outbid by a higher-priority node. That node withdraws on the following bit without corrupting the winner's frame, and it then continues as a receiver.

A frame controller pulses `frameStart` when the node begins a frame and `frameEnd` when the frame is over. On each bit it presents the bit to send on `txBit`, raises `sampleTick` when the bus level is valid, and holds `arbWindow` high across the identifier and request-type bits. The unit drives `busDrive` and reports its arbitration status. When the node is outbid it emits a one-cycle `rxSwitch` pulse. Any other difference between the driven and sampled levels while the node transmits is reported as a one-cycle `bitError` pulse. Dominant is logic 0 by default (parameter `DOMINANT`).

Top module: `wired_and_arbiter`

## Requirements
- R1: After reset, `arbStatus` is idle (2'b00), `busDrive` is recessive (1), and `rxSwitch` and `bitError` are 0.
- R2: The cycle after `frameStart`, `arbStatus` is contending (2'b01). While contending or won, `busDrive` equals `txBit`.
- R3: In the contending state, a tick with `arbWindow` high where the node drives recessive (1) and samples dominant (0) makes `arbStatus` lost (2'b11) in the next cycle, with `rxSwitch` high for exactly that one cycle.
- R4: While lost, `busDrive` stays recessive whatever `txBit` is, until the frame ends.
- R5: A tick where the sampled level equals the driven level leaves the status unchanged and raises neither pulse.
- R6: In the contending state, after at least one tick inside the window, the first tick with `arbWindow` low makes `arbStatus` won (2'b10). A node alone on an idle bus therefore wins. A frame with a dominant final window bit beats one with a recessive final bit when the identifiers are equal.
- R7: Inside the window, driving dominant and sampling recessive is not a loss. The status is unchanged and `bitError` pulses for one cycle.
- R8: Outside the window, any mismatch while the node transmits raises `bitError` and never `rxSwitch`. The status is unchanged.
- R9: The cycle after `frameEnd` (with no `frameStart`), `arbStatus` is idle and `busDrive` is recessive. `frameStart` takes priority when both are high.
- R10: Won and lost are held until the frame ends. In the lost state, later ticks (including dominant reads inside the window) change nothing and raise no pulse.
- R11: In the idle state, ticks have no effect: the status stays idle and no pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameStart | input | 1 | Node begins a frame; restarts contention |
| frameEnd | input | 1 | Frame finished; return to idle |
| sampleTick | input | 1 | Bus level is valid for the current bit |
| arbWindow | input | 1 | Current bit lies in the arbitration field |
| txBit | input | 1 | Bit the node wants to send in this slot |
| busLevel | input | 1 | Level sampled back from the shared line |
| busDrive | output | 1 | Level the node drives onto the line |
| arbStatus | output | 2 | 00 idle, 01 contending, 10 won, 11 lost |
| rxSwitch | output | 1 | One-cycle pulse when arbitration is lost |
| bitError | output | 1 | One-cycle pulse on a non-arbitration mismatch |

## Verification
The properties assume that `busLevel` is meaningful only on cycles with `sampleTick` high. They also assume that `frameStart` and `frameEnd` never share a cycle with a tick, because a frame boundary suppresses both pulses by design. The stimulus keeps every tick on its own cycle with idle cycles in between, and it places frame boundaries only between bits. The bench models a second node's bits as the sampled level, so that losses, wins and bit errors arise from realistic wired-AND outcomes.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    ARB_IDLE    = 2'b00,
    ARB_CONTEND = 2'b01,
    ARB_WON     = 2'b10,
    ARB_LOST    = 2'b11
  } arbState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clearWin;
    logic markWin;
    logic loseNow;
    logic errNow;
  } arbStrobe_t;

endpackage

// File: rtl/arb_datapath.sv
module arb_datapath #(
  parameter bit DOMINANT = 1'b0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                txBit,
  input  logic                busLevel,
  input  arb_pkg::arbState_e  stateQ,
  input  arb_pkg::arbStrobe_t strobe,
  output logic                busDrive,
  output logic                transmitting,
  output logic                drvRecRdDom,
  output logic                mismatch,
  output logic                windowSeen,
  output logic                rxSwitch,
  output logic                bitError
);
  import arb_pkg::*;

  localparam bit RECESSIVE = ~DOMINANT;

  always_comb begin
    transmitting = (stateQ == ARB_CONTEND) || (stateQ == ARB_WON);
    busDrive     = transmitting ? txBit : RECESSIVE;
    mismatch     = (busLevel != busDrive);
    drvRecRdDom  = (busDrive == RECESSIVE) && (busLevel == DOMINANT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      windowSeen <= 1'b0;
      rxSwitch   <= 1'b0;
      bitError   <= 1'b0;
    end else begin
      if (strobe.clearWin)     windowSeen <= 1'b0;
      else if (strobe.markWin) windowSeen <= 1'b1;
      rxSwitch <= strobe.loseNow;
      bitError <= strobe.errNow;
    end
  end

endmodule

// File: rtl/arb_control.sv
module arb_control (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 frameStart,
  input  logic                 frameEnd,
  input  logic                 sampleTick,
  input  logic                 arbWindow,
  input  logic                 transmitting,
  input  logic                 drvRecRdDom,
  input  logic                 mismatch,
  input  logic                 windowSeen,
  output arb_pkg::arbState_e   stateQ,
  output arb_pkg::arbStrobe_t  strobe
);
  import arb_pkg::*;

  arbState_e stateD;
  logic      bitSlot;
  logic      contending;
  logic      winNow;

  always_comb begin
    bitSlot    = sampleTick && !frameStart && !frameEnd;
    contending = (stateQ == ARB_CONTEND);

    strobe.clearWin = frameStart;
    strobe.markWin  = bitSlot && contending && arbWindow;
    strobe.loseNow  = bitSlot && contending && arbWindow && drvRecRdDom;
    strobe.errNow   = bitSlot && transmitting && mismatch && !strobe.loseNow;
    winNow          = bitSlot && contending && !arbWindow && windowSeen;

    stateD = stateQ;
    if (frameStart)          stateD = ARB_CONTEND;
    else if (frameEnd)       stateD = ARB_IDLE;
    else if (strobe.loseNow) stateD = ARB_LOST;
    else if (winNow)         stateD = ARB_WON;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ARB_IDLE;
    else       stateQ <= stateD;
  end

endmodule

// File: rtl/wired_and_arbiter.sv
module wired_and_arbiter #(
  parameter bit DOMINANT = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameStart,
  input  logic       frameEnd,
  input  logic       sampleTick,
  input  logic       arbWindow,
  input  logic       txBit,
  input  logic       busLevel,
  output logic       busDrive,
  output logic [1:0] arbStatus,
  output logic       rxSwitch,
  output logic       bitError
);
  import arb_pkg::*;

  arbState_e  stateQ;
  arbStrobe_t strobe;
  logic       transmitting;
  logic       drvRecRdDom;
  logic       mismatch;
  logic       windowSeen;

  arb_control ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .frameStart   (frameStart),
    .frameEnd     (frameEnd),
    .sampleTick   (sampleTick),
    .arbWindow    (arbWindow),
    .transmitting (transmitting),
    .drvRecRdDom  (drvRecRdDom),
    .mismatch     (mismatch),
    .windowSeen   (windowSeen),
    .stateQ       (stateQ),
    .strobe       (strobe)
  );

  arb_datapath #(.DOMINANT(DOMINANT)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .txBit        (txBit),
    .busLevel     (busLevel),
    .stateQ       (stateQ),
    .strobe       (strobe),
    .busDrive     (busDrive),
    .transmitting (transmitting),
    .drvRecRdDom  (drvRecRdDom),
    .mismatch     (mismatch),
    .windowSeen   (windowSeen),
    .rxSwitch     (rxSwitch),
    .bitError     (bitError)
  );

  assign arbStatus = stateQ;

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter bit DOMINANT = 1'b0
) (
  input logic       clk,
  input logic       rstN,
  input logic       frameStart,
  input logic       frameEnd,
  input logic       sampleTick,
  input logic       arbWindow,
  input logic       busLevel,
  input logic       busDrive,
  input logic [1:0] arbStatus,
  input logic       rxSwitch,
  input logic       bitError
);
  localparam bit RECESSIVE = ~DOMINANT;

  a_r2_start_contends: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> arbStatus == 2'b01);

  a_r3_loss_taken: assert property (@(posedge clk) disable iff (!rstN)
    (sampleTick && arbWindow && !frameStart && !frameEnd && arbStatus == 2'b01
     && busDrive == RECESSIVE && busLevel == DOMINANT)
    |=> (arbStatus == 2'b11 && rxSwitch));

  a_r3_pulse_in_lost: assert property (@(posedge clk) disable iff (!rstN)
    rxSwitch |-> arbStatus == 2'b11);

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rxSwitch |=> !rxSwitch);

  a_r4_lost_recessive: assert property (@(posedge clk) disable iff (!rstN)
    arbStatus == 2'b11 |-> busDrive == RECESSIVE);

  a_r8_no_double_report: assert property (@(posedge clk) disable iff (!rstN)
    !(rxSwitch && bitError));

  a_r9_idle_recessive: assert property (@(posedge clk) disable iff (!rstN)
    arbStatus == 2'b00 |-> busDrive == RECESSIVE);

  a_r10_lost_held: assert property (@(posedge clk) disable iff (!rstN)
    (arbStatus == 2'b11 && !frameStart && !frameEnd) |=> arbStatus == 2'b11);

  a_r10_won_held: assert property (@(posedge clk) disable iff (!rstN)
    (arbStatus == 2'b10 && !frameStart && !frameEnd) |=> arbStatus == 2'b10);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (arbStatus == 2'b00 && !frameStart) |=> (!rxSwitch && !bitError && arbStatus == 2'b00));

endmodule

bind wired_and_arbiter arb_checker #(.DOMINANT(DOMINANT)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .frameStart (frameStart),
  .frameEnd   (frameEnd),
  .sampleTick (sampleTick),
  .arbWindow  (arbWindow),
  .busLevel   (busLevel),
  .busDrive   (busDrive),
  .arbStatus  (arbStatus),
  .rxSwitch   (rxSwitch),
  .bitError   (bitError)
);

// File: tb/wired_and_arbiter_tb_top.sv
module wired_and_arbiter_tb_top;

  localparam logic [1:0] S_IDLE = 2'b00;
  localparam logic [1:0] S_CONT = 2'b01;
  localparam logic [1:0] S_WON  = 2'b10;
  localparam logic [1:0] S_LOST = 2'b11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 1'b0, frameEnd = 1'b0, sampleTick = 1'b0;
  logic arbWindow = 1'b0, txBit = 1'b1, busLevel = 1'b1;
  logic busDrive, rxSwitch, bitError;
  logic [1:0] arbStatus;

  always #2 clk = ~clk;

  wired_and_arbiter dut_i (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .frameEnd(frameEnd),
    .sampleTick(sampleTick), .arbWindow(arbWindow), .txBit(txBit),
    .busLevel(busLevel), .busDrive(busDrive), .arbStatus(arbStatus),
    .rxSwitch(rxSwitch), .bitError(bitError)
  );

  typedef struct {
    int         due;
    logic [1:0] st;
    logic       rx;
    logic       err;
    string      req;
  } expItem_t;

  expItem_t expQ[$];
  int   cycle = 0;
  int   total = 0;
  int   failed = 0;
  bit   done = 1'b0;
  logic [1:0] mState = S_IDLE;
  bit   mSeen = 1'b0;

  always @(posedge clk) cycle++;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: pops expectations when due
  initial begin
    forever begin
      @(negedge clk);
      while (expQ.size() > 0 && expQ[0].due <= cycle) begin
        expItem_t it;
        it = expQ.pop_front();
        check({arbStatus, rxSwitch, bitError} == {it.st, it.rx, it.err}, it.req,
              "status/rx/err", int'({arbStatus, rxSwitch, bitError}),
              int'({it.st, it.rx, it.err}));
      end
    end
  end

  task automatic push(input logic [1:0] st, input logic rx, input logic err,
                      input string req);
    expItem_t it;
    it.due = cycle + 1; it.st = st; it.rx = rx; it.err = err; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic startFrame(input string req);
    @(negedge clk);
    frameStart = 1'b1;
    mState = S_CONT; mSeen = 1'b0;
    push(S_CONT, 1'b0, 1'b0, req);
    @(negedge clk);
    frameStart = 1'b0;
  endtask

  task automatic endFrame(input string req);
    @(negedge clk);
    frameEnd = 1'b1;
    mState = S_IDLE;
    push(S_IDLE, 1'b0, 1'b0, req);
    @(negedge clk);
    frameEnd = 1'b0;
    #1 check(busDrive == 1'b1, req, "busDrive after end", busDrive, 1);
  endtask

  // one bit slot: tx is our bit, bus is the wired-AND level seen on the line
  task automatic bitSlot(input logic tx, input logic bus, input logic win,
                         input string req);
    bit xmit, lose, err;
    logic expDrive;
    logic [1:0] nxt;
    @(negedge clk);
    txBit = tx; busLevel = bus; arbWindow = win; sampleTick = 1'b1;
    xmit = (mState == S_CONT) || (mState == S_WON);
    expDrive = xmit ? tx : 1'b1;
    #1 check(busDrive == expDrive, req, "busDrive", busDrive, expDrive);
    lose = (mState == S_CONT) && win && expDrive && !bus;
    err  = xmit && (bus != expDrive) && !lose;
    nxt = mState;
    if (lose) nxt = S_LOST;
    else if (mState == S_CONT && win) mSeen = 1'b1;
    else if (mState == S_CONT && !win && mSeen) nxt = S_WON;
    push(nxt, lose, err, req);
    mState = nxt;
    @(negedge clk);
    sampleTick = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  endtask

  initial begin
    #(4 * 60000);
    total++; failed++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    #5;
    // R1: reset state
    check(arbStatus == S_IDLE, "R1", "status", arbStatus, S_IDLE);
    check(busDrive == 1'b1, "R1", "busDrive", busDrive, 1);
    check(!rxSwitch && !bitError, "R1", "pulses", {rxSwitch, bitError}, 0);
    @(negedge clk); rstN = 1'b1;

    // R11: ticks while idle do nothing, even with a dominant bus
    bitSlot(1'b0, 1'b0, 1'b1, "R11");
    bitSlot(1'b1, 1'b0, 1'b0, "R11");

    // Frame A: alone on the bus, wins, then an out-of-window error
    startFrame("R2");
    bitSlot(1'b0, 1'b0, 1'b1, "R5");
    bitSlot(1'b1, 1'b1, 1'b1, "R5");
    bitSlot(1'b0, 1'b0, 1'b1, "R2");
    bitSlot(1'b1, 1'b1, 1'b0, "R6");   // first bit after window: won
    bitSlot(1'b0, 1'b0, 1'b0, "R10");
    bitSlot(1'b1, 1'b0, 1'b0, "R8");   // out-of-window recessive/dominant
    bitSlot(1'b0, 1'b1, 1'b0, "R8");   // out-of-window dominant/recessive
    bitSlot(1'b1, 1'b1, 1'b1, "R10");  // window again: still won
    endFrame("R9");

    // Frame B: outbid on the third identifier bit
    startFrame("R2");
    bitSlot(1'b0, 1'b0, 1'b1, "R5");
    bitSlot(1'b1, 1'b1, 1'b1, "R5");
    bitSlot(1'b1, 1'b0, 1'b1, "R3");
    bitSlot(1'b0, 1'b0, 1'b1, "R4");   // our dominant bit not driven
    bitSlot(1'b0, 1'b1, 1'b1, "R4");
    bitSlot(1'b1, 1'b0, 1'b1, "R10");  // dominant read while lost: no pulse
    bitSlot(1'b0, 1'b1, 1'b0, "R10");  // window closed: stays lost
    endFrame("R9");

    // Frame C: dominant driven, recessive read inside window is an error only
    startFrame("R2");
    bitSlot(1'b0, 1'b1, 1'b1, "R7");
    bitSlot(1'b1, 1'b1, 1'b1, "R5");
    bitSlot(1'b0, 1'b0, 1'b0, "R6");
    endFrame("R9");

    // Frame D: remote request loses final window bit to a data frame
    startFrame("R2");
    bitSlot(1'b1, 1'b1, 1'b1, "R5");
    bitSlot(1'b0, 1'b0, 1'b1, "R5");
    bitSlot(1'b1, 1'b0, 1'b1, "R3");   // request-type bit: recessive loses
    bitSlot(1'b1, 1'b1, 1'b0, "R10");
    endFrame("R9");

    // Frame E: data frame side wins with dominant final window bit
    startFrame("R2");
    bitSlot(1'b1, 1'b1, 1'b1, "R5");
    bitSlot(1'b0, 1'b0, 1'b1, "R5");
    bitSlot(1'b0, 1'b0, 1'b1, "R6");
    bitSlot(1'b1, 1'b1, 1'b0, "R6");
    // restart while won: frameStart with frameEnd, start has priority
    @(negedge clk);
    frameStart = 1'b1; frameEnd = 1'b1;
    mState = S_CONT; mSeen = 1'b0;
    push(S_CONT, 1'b0, 1'b0, "R9");
    @(negedge clk);
    frameStart = 1'b0; frameEnd = 1'b0;
    bitSlot(1'b1, 1'b1, 1'b0, "R2");   // no window bit yet: no win
    endFrame("R9");

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R9", "pending expectations", expQ.size(), 0);
    finishRun();
  end

endmodule